// File: doc/BRIEF.md
# Sprite Display-List Fetch Sequencer

This block is the fetch engine for one sprite channel. It walks a list held in word-addressed memory so that a single sprite can appear several times in one video field. Each appearance is described by two control words holding its vertical first line, its vertical stop line and its horizontal position. These are followed by one pair of image words for every line the sprite covers. After the image words comes the control pair of the next appearance, or a pair of zero words that closes the list.

The channel owns two memory read slots on every scan line. While the current line lies inside an appearance, both slots fetch image words, and the pair goes to the sprite serializer with a one-cycle strobe. On the stop line, the slots read the next control pair instead. That line is therefore blank for this sprite, and a later appearance must start below it. A field-start pulse reloads the list pointer from `list_base`, and the first control pair is fetched on that same line. Eight such channels run side by side in a full display, each with its own instance. Arbitration between the channels, pixel shifting and priority are handled outside this block.

Top module: `sprite_list_seq`

## Requirements
- R1: After reset, and until the first `field_start`, `mem_rd`, `data_vld` and `pos_vld` stay low and the position outputs read zero.
- R2: On `field_start`, the list pointer (`mem_addr`) takes the value of `list_base` from the next cycle, and the control pair is read in the granted slots of that same line.
- R3: A read happens only in a cycle with both `mem_rd` and `slot_gnt` high. The block makes at most two reads per line, and each read advances `mem_addr` by one word, so a pair advances it by two.
- R4: A control pair (w0, w1) is decoded as follows. Vertical start is {w1[2], w0[15:8]}. Vertical stop is {w1[1], w1[15:8]}. Horizontal start is {w0[7:0], w1[0]}. The outputs take these values and `pos_vld` pulses for one cycle in the cycle after the second word arrives.
- R5: Image words are fetched on lines from vertical start up to vertical stop minus one. The first word appears on `data_a` and the second on `data_b`, with `data_vld` high for one cycle in the cycle after the second word arrives.
- R6: On the line whose number equals vertical stop, the two slots read the next control pair, and no image pair is delivered on that line.
- R7: A control pair of two zero words produces no `pos_vld` and leaves the position outputs unchanged. After it, no read is made for the rest of the field.
- R8: If an appearance's vertical start is not greater than the line on which its control pair was read, the block shows nothing for it and makes no further read in that field.
- R9: A `field_start` that arrives in the middle of an appearance abandons it, and the list restarts from `list_base`.
- R10: An appearance whose vertical start is the line right after the previous stop line is displayed from that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start | input | 1 | One-cycle pulse at the start of a field; reloads the list pointer |
| list_base | input | AW | Word address of the first control pair of the list |
| line_start | input | 1 | One-cycle pulse opening each scan line |
| line_num | input | 9 | Number of the line being opened, valid with `line_start` |
| slot_gnt | input | 1 | A memory slot is offered to this channel in this cycle |
| mem_rd | output | 1 | The channel wants to read `mem_addr` |
| mem_addr | output | AW | Word address of the next read |
| mem_rdata | input | 16 | Read data, valid the cycle after a granted read |
| data_vld | output | 1 | One-cycle strobe: new image pair on `data_a`/`data_b` |
| data_a | output | 16 | First image word of the pair |
| data_b | output | 16 | Second image word of the pair |
| pos_vld | output | 1 | One-cycle strobe: new position decoded |
| spr_vstart | output | 9 | Vertical start line of the current appearance |
| spr_vstop | output | 9 | Vertical stop line of the current appearance |
| spr_hstart | output | 9 | Horizontal start position of the current appearance |

## Verification
The hardest case to reach from the ports is an appearance with a vertical start that needs bit 8. It ends right before a second appearance whose start equals the gap line, which makes the sequencer wait forever. The stimulus gets there by running a full 270-line field, so that line numbers pass 255, and by placing the second control pair with a start on the stop line itself. A second hard case is a field restart while image words are still being fetched. The bench produces it by cutting one field short at line 11, inside the first appearance, and starting the next field at once.

// File: rtl/sprseq_pkg.sv
// Package: shared constants, the sequencer state type, the decoded
// position record and the control-pair decode for the sprite list fetcher.
// Assumes 16-bit memory words and 9-bit line and position values.
package sprseq_pkg;

    localparam int WORD_W = 16;
    localparam int POS_W  = 9;
    localparam int SLOTS_PER_LINE = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // list finished or no field started
        ST_ARMED = 2'd1,   // position known, waiting for the first line
        ST_IMAGE = 2'd2,   // fetching one image pair per line
        ST_CTRL  = 2'd3    // fetching a control pair this line
    } seq_state_e;

    typedef struct packed {
        logic [POS_W-1:0] vfirst;
        logic [POS_W-1:0] vstop;
        logic [POS_W-1:0] hpos;
    } spr_pos_t;

    // Unpack the two control words into a position record.
    function automatic spr_pos_t unpack_ctrl(input logic [WORD_W-1:0] w0,
                                             input logic [WORD_W-1:0] w1);
        spr_pos_t p;
        p.vfirst = {w1[2], w0[15:8]};
        p.vstop  = {w1[1], w1[15:8]};
        p.hpos   = {w0[7:0], w1[0]};
        return p;
    endfunction

    // A pair of all-zero words closes the list.
    function automatic logic is_list_end(input logic [WORD_W-1:0] w0,
                                         input logic [WORD_W-1:0] w1);
        return (w0 == '0) && (w1 == '0);
    endfunction

endpackage

// File: rtl/sprseq_fetch.sv
// Module: sprseq_fetch
// Owns the list pointer and the per-line slot budget. It issues reads while
// enabled and a slot is left on this line. Read data returns one cycle after
// a granted read, and the module assembles two returned words into a pair.
// Assumes the memory answers every granted read exactly one cycle later.
module sprseq_fetch
    import sprseq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              line_start,
    input  logic              fetch_en,
    input  logic [AW-1:0]     list_base,
    input  logic              slot_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    output logic              pair_done,
    output logic [WORD_W-1:0] pair_w0,
    output logic [WORD_W-1:0] pair_w1
);

    localparam int CW = $clog2(SLOTS_PER_LINE + 1);
    localparam logic [CW-1:0] SLOT_MAX  = CW'(SLOTS_PER_LINE);
    localparam logic [CW-1:0] SLOT_LAST = CW'(SLOTS_PER_LINE - 1);

    logic [AW-1:0]     ptr_q;
    logic [CW-1:0]     used_q;
    logic              pend_q;
    logic              pend_last_q;
    logic [WORD_W-1:0] first_q;
    logic              take;

    assign mem_rd   = fetch_en && (used_q < SLOT_MAX);
    assign take     = mem_rd && slot_gnt;
    assign mem_addr = ptr_q;

    // List pointer: reload at field start, one word per granted read.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (reload) ptr_q <= list_base;
        else if (take)   ptr_q <= ptr_q + AW'(1);
    end

    // Slots used on the current line.
    always_ff @(posedge clk) begin
        if (!rst_n)          used_q <= '0;
        else if (reload)     used_q <= '0;
        else if (line_start) used_q <= take ? CW'(1) : '0;
        else if (take)       used_q <= used_q + CW'(1);
    end

    // Marks a read in flight and whether it is the second of its pair.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            pend_q      <= 1'b0;
            pend_last_q <= 1'b0;
        end else begin
            pend_q      <= take;
            pend_last_q <= (used_q == SLOT_LAST);
        end
    end

    // Holds the first word of a pair until the second returns.
    always_ff @(posedge clk) begin
        if (!rst_n)                     first_q <= '0;
        else if (pend_q && !pend_last_q) first_q <= mem_rdata;
    end

    assign pair_done = pend_q && pend_last_q;
    assign pair_w0   = first_q;
    assign pair_w1   = mem_rdata;

endmodule

// File: rtl/sprseq_ctrl.sv
// Module: sprseq_ctrl
// Sequencer state machine and position registers. State changes at field
// start, at line start (first line reached, stop line reached) and when a
// control pair completes. Assumes pairs never complete on a line-start cycle.
module sprseq_ctrl
    import sprseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              line_start,
    input  logic [POS_W-1:0]  line_num,
    input  logic              pair_done,
    input  logic [WORD_W-1:0] pair_w0,
    input  logic [WORD_W-1:0] pair_w1,
    output logic              fetch_en,
    output logic              img_take,
    output logic              pos_vld,
    output spr_pos_t          pos
);

    seq_state_e state_q;
    seq_state_e state_d;
    spr_pos_t   dec;
    logic       ctrl_take;
    logic       list_end;

    assign dec       = unpack_ctrl(pair_w0, pair_w1);
    assign list_end  = is_list_end(pair_w0, pair_w1);
    assign ctrl_take = pair_done && (state_q == ST_CTRL);
    assign img_take  = pair_done && (state_q == ST_IMAGE);
    assign fetch_en  = (state_q == ST_IMAGE) || (state_q == ST_CTRL);

    // Next state: reload first, then line boundaries, then pair completion.
    always_comb begin
        state_d = state_q;
        if (reload) begin
            state_d = ST_CTRL;
        end else if (line_start) begin
            if (state_q == ST_ARMED && line_num == pos.vfirst)
                state_d = ST_IMAGE;
            else if (state_q == ST_IMAGE && line_num == pos.vstop)
                state_d = ST_CTRL;
        end else if (ctrl_take) begin
            state_d = list_end ? ST_IDLE : ST_ARMED;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Position registers and their strobe, loaded from a non-end control pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= '0;
            pos_vld <= 1'b0;
        end else begin
            pos_vld <= ctrl_take && !list_end;
            if (ctrl_take && !list_end) pos <= dec;
        end
    end

endmodule

// File: rtl/sprseq_emit.sv
// Module: sprseq_emit
// Registers a completed image pair towards the serializer with a one-cycle
// valid strobe. Assumes at most one pair completes per cycle.
module sprseq_emit
    import sprseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              img_take,
    input  logic [WORD_W-1:0] pair_w0,
    input  logic [WORD_W-1:0] pair_w1,
    output logic              data_vld,
    output logic [WORD_W-1:0] data_a,
    output logic [WORD_W-1:0] data_b
);

    // Output pair and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_vld <= 1'b0;
            data_a   <= '0;
            data_b   <= '0;
        end else begin
            data_vld <= img_take;
            if (img_take) begin
                data_a <= pair_w0;
                data_b <= pair_w1;
            end
        end
    end

endmodule

// File: rtl/sprite_list_seq.sv
// Module: sprite_list_seq
// One sprite channel's display-list fetcher: pointer and slot budget,
// state machine with positions, and image output register. Assumes two
// slot grants per line, after the line-start cycle, and one-cycle read latency.
module sprite_list_seq
    import sprseq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic [AW-1:0]     list_base,
    input  logic              line_start,
    input  logic [POS_W-1:0]  line_num,
    input  logic              slot_gnt,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              data_vld,
    output logic [WORD_W-1:0] data_a,
    output logic [WORD_W-1:0] data_b,
    output logic              pos_vld,
    output logic [POS_W-1:0]  spr_vstart,
    output logic [POS_W-1:0]  spr_vstop,
    output logic [POS_W-1:0]  spr_hstart
);

    logic              fetch_en;
    logic              pair_done;
    logic [WORD_W-1:0] pair_w0;
    logic [WORD_W-1:0] pair_w1;
    logic              img_take;
    spr_pos_t          pos;

    sprseq_fetch #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (field_start),
        .line_start (line_start),
        .fetch_en   (fetch_en),
        .list_base  (list_base),
        .slot_gnt   (slot_gnt),
        .mem_rdata  (mem_rdata),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .pair_done  (pair_done),
        .pair_w0    (pair_w0),
        .pair_w1    (pair_w1)
    );

    sprseq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (field_start),
        .line_start (line_start),
        .line_num   (line_num),
        .pair_done  (pair_done),
        .pair_w0    (pair_w0),
        .pair_w1    (pair_w1),
        .fetch_en   (fetch_en),
        .img_take   (img_take),
        .pos_vld    (pos_vld),
        .pos        (pos)
    );

    sprseq_emit u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .img_take (img_take),
        .pair_w0  (pair_w0),
        .pair_w1  (pair_w1),
        .data_vld (data_vld),
        .data_a   (data_a),
        .data_b   (data_b)
    );

    assign spr_vstart = pos.vfirst;
    assign spr_vstop  = pos.vstop;
    assign spr_hstart = pos.hpos;

endmodule

// File: rtl/sprite_list_seq_chk.sv
// Module: sprite_list_seq_chk
// Port-level temporal checks for sprite_list_seq, attached by bind.
module sprite_list_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          field_start,
    input logic          line_start,
    input logic          slot_gnt,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] list_base,
    input logic          data_vld,
    input logic          pos_vld
);

    logic [1:0] reads_ln;

    // Counts granted reads since the last line or field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                         reads_ln <= '0;
        else if (field_start || line_start) reads_ln <= '0;
        else if (mem_rd && slot_gnt && reads_ln != 2'd3) reads_ln <= reads_ln + 2'd1;
    end

    p_line_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && slot_gnt && !line_start && !field_start) |-> (reads_ln < 2'd2));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && slot_gnt && !field_start) |=> (mem_addr == $past(mem_addr) + AW'(1)));

    p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (mem_addr == $past(list_base)));

    p_data_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |=> !data_vld);

    p_pos_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pos_vld |=> !pos_vld);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_vld && pos_vld));

endmodule

bind sprite_list_seq sprite_list_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .line_start  (line_start),
    .slot_gnt    (slot_gnt),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .list_base   (list_base),
    .data_vld    (data_vld),
    .pos_vld     (pos_vld)
);

// File: tb/sprite_list_seq_tb_top.sv
// Bench: behavioural per-cycle reference model compared on every clock.
module sprite_list_seq_tb_top;

    localparam int AW = 16;
    localparam int LINE_CYC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          field_start = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic          line_start = 1'b0;
    logic [8:0]    line_num = '0;
    logic          slot_gnt = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata = '0;
    logic          data_vld;
    logic [15:0]   data_a;
    logic [15:0]   data_b;
    logic          pos_vld;
    logic [8:0]    spr_vstart;
    logic [8:0]    spr_vstop;
    logic [8:0]    spr_hstart;

    always #2 clk = ~clk;

    sprite_list_seq #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .list_base(list_base),
        .line_start(line_start), .line_num(line_num), .slot_gnt(slot_gnt),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .data_vld(data_vld), .data_a(data_a), .data_b(data_b), .pos_vld(pos_vld),
        .spr_vstart(spr_vstart), .spr_vstop(spr_vstop), .spr_hstart(spr_hstart)
    );

    logic [15:0] mem [0:511];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model: 0 idle, 1 armed, 2 image, 3 control
    int m_st = 0, m_ptr = 0, m_cnt = 0, m_pend = 0, m_pidx = 0, m_w0 = 0;
    int m_vs = 0, m_ve = 0, m_hs = 0, m_dvld = 0, m_da = 0, m_db = 0, m_pvld = 0;
    int prev_rd = 0, prev_addr = 0;

    // per-field observations from the ports
    int f_reads, f_dvld, f_pvld, f_quiet_reads, p_reads, p_dvld, p_pvld;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void put_ctrl(input int a, input int vs, input int ve, input int hs);
        mem[a]   = 16'(((vs & 255) << 8) | ((hs >> 1) & 255));
        mem[a+1] = 16'(((ve & 255) << 8) | (((vs >> 8) & 1) << 2) | (((ve >> 8) & 1) << 1) | (hs & 1));
    endfunction

    // One clock: compare, drive inputs, advance the model, wait.
    task automatic cyc(input bit ls, input bit fs, input int ln, input bit g, input int base,
                       input int quiet_from, input int probe);
        int e_rd, rd, rdat, nd, np, npend, npidx;
        e_rd = ((m_st == 2) || (m_st == 3)) && (m_cnt < 2);
        chk(mem_rd == e_rd[0], "R3 mem_rd", int'(mem_rd), e_rd);
        chk(int'(mem_addr) == m_ptr, "R2 mem_addr", int'(mem_addr), m_ptr);
        chk(data_vld == m_dvld[0] && (m_dvld == 0 || (int'(data_a) == m_da && int'(data_b) == m_db)),
            "R5 image pair", {data_vld, data_a}, {m_dvld[0], m_da[15:0]});
        chk(pos_vld == m_pvld[0] && int'(spr_vstart) == m_vs && int'(spr_vstop) == m_ve
            && int'(spr_hstart) == m_hs, "R4 position", {pos_vld, spr_vstart, spr_hstart},
            {m_pvld[0], m_vs[8:0], m_hs[8:0]});
        rdat = prev_rd ? int'(mem[prev_addr]) : 0;
        line_start = ls; field_start = fs; line_num = 9'(ln); slot_gnt = g;
        list_base = AW'(base); mem_rdata = 16'(rdat);
        if (mem_rd && g) begin
            f_reads++;
            if (ln > quiet_from) f_quiet_reads++;
            if (ln == probe) p_reads++;
        end
        if (data_vld) begin f_dvld++; if (ln == probe) p_dvld++; end
        if (pos_vld)  begin f_pvld++; if (ln == probe) p_pvld++; end
        rd = e_rd && g;
        nd = 0; np = 0;
        if (m_pend != 0) begin
            if (m_pidx == 0) m_w0 = rdat;
            else if (m_st == 2) begin m_da = m_w0; m_db = rdat; nd = 1; end
            else if (m_st == 3) begin
                if (m_w0 == 0 && rdat == 0) m_st = 0;
                else begin
                    m_vs = (m_w0 >> 8) + ((rdat >> 2) & 1) * 256;
                    m_ve = (rdat >> 8) + ((rdat >> 1) & 1) * 256;
                    m_hs = (m_w0 & 255) * 2 + (rdat & 1);
                    np = 1; m_st = 1;
                end
            end
        end
        npend = rd; npidx = m_cnt;
        prev_rd = rd; prev_addr = m_ptr & 511;
        if (rd != 0) begin m_ptr = m_ptr + 1; m_cnt = m_cnt + 1; end
        if (ls) begin
            m_cnt = rd;
            if (m_st == 1 && ln == m_vs) m_st = 2;
            else if (m_st == 2 && ln == m_ve) m_st = 3;
        end
        if (fs) begin m_ptr = base; m_st = 3; m_cnt = 0; npend = 0; end
        m_pend = npend; m_pidx = npidx; m_dvld = nd; m_pvld = np;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Runs one field of nlines lines and checks the field's counts.
    task automatic run_field(input bit fs, input int base, input int nlines,
                             input int x_reads, input int x_dvld, input int x_pvld,
                             input int quiet_from, input int probe,
                             input int xp_reads, input int xp_dvld, input int xp_pvld,
                             input string tag);
        f_reads = 0; f_dvld = 0; f_pvld = 0; f_quiet_reads = 0;
        p_reads = 0; p_dvld = 0; p_pvld = 0;
        for (int ln = 0; ln < nlines; ln++) begin
            for (int c = 0; c < LINE_CYC; c++) begin
                cyc(c == 0, fs && ln == 0 && c == 0, ln, c == 2 || c == 4, base, quiet_from, probe);
                if (fs && ln == 0 && c == 0)
                    chk(int'(mem_addr) == base, {tag, " R2 R9 pointer reload"}, int'(mem_addr), base);
            end
        end
        chk(f_reads == x_reads, {tag, " R3 reads in field"}, f_reads, x_reads);
        chk(f_dvld == x_dvld, {tag, " R5 image pairs"}, f_dvld, x_dvld);
        chk(f_pvld == x_pvld, {tag, " R4 positions"}, f_pvld, x_pvld);
        chk(f_quiet_reads == 0, {tag, " R7 R8 no reads after list stops"}, f_quiet_reads, 0);
        chk(p_reads == xp_reads && p_dvld == xp_dvld && p_pvld == xp_pvld,
            {tag, " probe line (R6 R10)"}, p_reads * 256 + p_dvld * 16 + p_pvld,
            xp_reads * 256 + xp_dvld * 16 + xp_pvld);
    endtask

    initial begin
        for (int a = 0; a < 512; a++) mem[a] = 16'(a * 257) ^ 16'h5A3C;
        put_ctrl(16, 10, 13, 'h155);   // field A first use, lines 10..12
        put_ctrl(24, 14, 16, 'h0C2);   // second use right after gap line 13
        mem[30] = 16'h0; mem[31] = 16'h0;
        put_ctrl(100, 260, 263, 'h1AB); // field B, start needs bit 8
        put_ctrl(108, 263, 270, 'h003); // start on its own fetch line: never shown
        mem[200] = 16'h0; mem[201] = 16'h0; // field C: empty list

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!mem_rd && !data_vld && !pos_vld, "R1 strobes after reset",
            {mem_rd, data_vld, pos_vld}, 0);
        chk(spr_vstart == 0 && spr_vstop == 0 && spr_hstart == 0, "R1 positions after reset",
            {spr_vstart, spr_hstart}, 0);
        // R1: lines without a field start make no reads
        run_field(0, 0, 3, 0, 0, 0, -1, 0, 0, 0, 0, "pre");
        // field A: R6 probe on gap line 13, R7 quiet after end at line 16
        run_field(1, 16, 20, 16, 5, 2, 16, 13, 2, 0, 1, "A");
        // field B: R4 bit 8 decode, R8 stuck use, probe gap line 263
        run_field(1, 100, 270, 10, 3, 2, 263, 263, 2, 0, 1, "B");
        // field C: R7 immediate end marker
        chk(spr_vstart == 9'd263 && spr_vstop == 9'd270 && spr_hstart == 9'h003,
            "R8 decoded position of unshown use", spr_vstart, 263);
        run_field(1, 200, 5, 2, 0, 0, 0, 0, 2, 0, 0, "C");
        chk(spr_vstart == 9'd263 && spr_hstart == 9'h003, "R7 end marker keeps position",
            spr_vstart, 263);
        // field D: cut inside the first use, then restart (R9), probe line 14 (R10)
        run_field(1, 16, 12, 6, 2, 1, 12, 11, 2, 1, 0, "D1");
        run_field(1, 16, 20, 16, 5, 2, 16, 14, 2, 1, 0, "D2");
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule